// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers fifteen interrupt lines, numbered 1 to 15, and routes them to a parameterised number of processors, from one to sixteen. An interrupt can be recorded in two ways. A shared pending vector holds ordinary interrupts. Each processor also has its own force vector, which software writes and which receives broadcast interrupts. Each processor has an enable mask. A global level vector splits the interrupt numbers into a high-priority group and a low-priority group. From this state the block drives a registered 4-bit request number to every processor.

Software reaches all state through a 32-bit register port with an 8-bit byte address. A write takes effect on the clock edge. A read returns data combinationally from the presented address. Processors retire interrupts through per-processor acknowledge strobes that carry an interrupt number. A start-control register keeps one idle flag per processor. Writing a one to a flag releases that processor with a one-cycle start pulse.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0 except the start-control word. That word reads (NCPU-1) in bits 31:28 and ones in bits 1 to NCPU-1, with bit 0 clear. All request outputs and start pulses are 0.
- R2: Bit 0 is never stored. Writes to the level, mask, broadcast, force, force-alias and clear registers keep only bits 15:1 of the write data.
- R3: On every cycle that input line k (k from 1 to 15) is high and broadcast bit k is 0, pending bit k is set on the next edge. A set in the same cycle as a clear-register write or an acknowledge of that bit wins.
- R4: While broadcast bit k is 1, a high line k sets bit k in every processor's force vector and leaves pending unchanged.
- R5: For processor n, the candidates are (pending | force[n]) & mask[n]. irq_req for n is the number of the highest candidate whose level bit is 1. If no such candidate exists, it is the highest candidate whose level bit is 0. If there is no candidate, it is 0. The output is registered one cycle after the state changes.
- R6: A write to the per-processor force register at 0x80+4n gives force[n] = (force[n] | wdata[15:1]) & ~wdata[31:17]. Bit 16+k clears bit k, so a clear wins over a set in the same write.
- R7: A write to the alias at 0x08 replaces force[0] with wdata[15:1]. A read at 0x08 returns force[0].
- R8: A write to the clear register at 0x0C removes the written bits from pending and from every force vector. 0x0C reads as 0. The pending register at 0x04 ignores writes.
- R9: An acknowledge from processor n with number k (ack_num bits 4n+3:4n) clears pending bit k and force[n] bit k on the next edge.
- R10: At the start-control word (0x10), writing a one to bit i (1 ≤ i < NCPU) clears idle bit i and pulses cpu_start[i] high for exactly the next cycle. Writing a zero never sets an idle bit. Bit 0 and bits 31:28 do not change on a write.
- R11: The per-processor extension register at 0xC0+4n stores only wdata[3:0] and reads back zero-extended.
- R12: The register map is level 0x00, pending 0x04, alias 0x08, clear 0x0C, start-control 0x10, broadcast 0x14, mask 0x40+4n, force 0x80+4n and extension 0xC0+4n. Any other offset reads 0 and ignores writes. This includes a per-processor slot with n ≥ NCPU and any offset with nonzero bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_lines | input | 16 | Interrupt lines, bit 0 unused |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_num | input | 4*NCPU | Acknowledged number, 4 bits per processor |
| irq_req | output | 4*NCPU | Registered request number, 4 bits per processor |
| cpu_start | output | NCPU | One-cycle start pulse per processor |

## Verification
The bound checker checks four things on every cycle. A start pulse always follows a write of a one to that processor's start-control bit, and idle flags never rise again. A nonzero request number always names an interrupt that the processor's mask enabled. An acknowledge or a line event leaves pending in the state that R9 and R3 require on the next edge. The scoreboard scenarios cover the rest: priority between level groups, set/clear encoding of force writes, the alias replacement, broadcast fan-out, precedence of a line over a clear, and the decoding of unmapped offsets. These depend on sequences of writes and readback that a single-cycle property cannot capture.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int AW       = 8;
    localparam int DW       = 32;
    localparam int LINES    = 16;
    localparam int NUM_W    = 4;
    localparam int IDX_W    = 4;
    localparam int EXT_W    = 4;
    localparam int CNT_W    = 4;
    localparam int MAX_CPU  = 16;

    typedef logic [LINES-1:0] vec_t;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_MASK   = 2'd1,
        GRP_FORCE  = 2'd2,
        GRP_EXT    = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        G_LEVEL,
        G_PEND,
        G_ALIAS,
        G_CLEAR,
        G_START,
        G_BCAST,
        G_NONE
    } gsel_e;

    typedef struct packed {
        logic             hit;
        grp_e             grp;
        gsel_e            gsel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    // Word slot inside the global group selects the register; the order is
    // fixed because software and the alias depend on these offsets.
    function automatic dec_t decode(input logic [AW-1:0] a, input int unsigned ncpu);
        dec_t d;
        d.grp  = grp_e'(a[AW-1:AW-2]);
        d.idx  = a[IDX_W+1:2];
        d.gsel = G_NONE;
        d.hit  = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (d.grp == GRP_GLOBAL) begin
                case (d.idx)
                    4'd0:    d.gsel = G_LEVEL;
                    4'd1:    d.gsel = G_PEND;
                    4'd2:    d.gsel = G_ALIAS;
                    4'd3:    d.gsel = G_CLEAR;
                    4'd4:    d.gsel = G_START;
                    4'd5:    d.gsel = G_BCAST;
                    default: d.gsel = G_NONE;
                endcase
                d.hit = (d.gsel != G_NONE);
            end else begin
                d.hit = (32'(d.idx) < ncpu);
            end
        end
        return d;
    endfunction

    function automatic vec_t clean(input logic [LINES-1:0] v);
        return v & ~vec_t'(1);
    endfunction

    function automatic logic [NUM_W-1:0] top_bit(input vec_t v);
        logic [NUM_W-1:0] r;
        r = '0;
        for (int i = 1; i < LINES; i++) begin
            if (v[i]) r = NUM_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/mpic_regfile.sv
module mpic_regfile
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  dec_t                       dec,
    input  logic [DW-1:0]              wdata,
    input  logic [LINES-1:0]           lines,
    input  logic [NCPU-1:0]            ack_valid,
    input  logic [NCPU-1:0][NUM_W-1:0] ack_num,
    output vec_t                       level_q,
    output vec_t                       pending_q,
    output vec_t                       bcast_q,
    output logic [NCPU-1:0][LINES-1:0] mask_q,
    output logic [NCPU-1:0][LINES-1:0] force_q,
    output logic [NCPU-1:0][EXT_W-1:0] ext_q,
    output logic [NCPU-1:0]            idle_q,
    output logic [NCPU-1:0]            start_q,
    output logic [DW-1:0]              status_word
);

    localparam logic [NCPU-1:0] ONE      = 1;
    localparam logic [NCPU-1:0] IDLE_RST = ~ONE;

    logic glob_wr;
    logic lvl_wr, bc_wr, alias_wr, clr_wr, st_wr;

    assign glob_wr  = wr && dec.hit && (dec.grp == GRP_GLOBAL);
    assign lvl_wr   = glob_wr && (dec.gsel == G_LEVEL);
    assign bc_wr    = glob_wr && (dec.gsel == G_BCAST);
    assign alias_wr = glob_wr && (dec.gsel == G_ALIAS);
    assign clr_wr   = glob_wr && (dec.gsel == G_CLEAR);
    assign st_wr    = glob_wr && (dec.gsel == G_START);

    vec_t wr_lo, wr_hi, clr_vec, line_set, bc_set, pend_set, ack_any;
    logic [NCPU-1:0][LINES-1:0] ack_vec;
    logic [NCPU-1:0][LINES-1:0] mask_nx, force_nx;
    logic [NCPU-1:0][EXT_W-1:0] ext_nx;
    logic [NCPU-1:0]            start_nx;
    vec_t                       pending_nx;

    assign wr_lo    = clean(wdata[LINES-1:0]);
    assign wr_hi    = clean(wdata[2*LINES-1:LINES]);
    assign clr_vec  = clr_wr ? wr_lo : '0;
    assign line_set = clean(lines);
    assign bc_set   = line_set & bcast_q;
    assign pend_set = line_set & ~bcast_q;
    assign start_nx = st_wr ? (wdata[NCPU-1:0] & IDLE_RST) : '0;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        localparam bit IS_FIRST = (c == 0);
        logic hit_c;
        vec_t f_after_wr;

        assign hit_c = wr && dec.hit && (dec.idx == IDX_W'(c));
        assign ack_vec[c] = ack_valid[c] ? (vec_t'(1) << ack_num[c]) : '0;

        // Register write first, then clears and acknowledges, then line sets.
        assign f_after_wr = (IS_FIRST && alias_wr) ? wr_lo :
                            (hit_c && dec.grp == GRP_FORCE) ? ((force_q[c] | wr_lo) & ~wr_hi) :
                            force_q[c];
        assign force_nx[c] = (f_after_wr & ~clr_vec & ~ack_vec[c]) | bc_set;
        assign mask_nx[c]  = (hit_c && dec.grp == GRP_MASK) ? wr_lo : mask_q[c];
        assign ext_nx[c]   = (hit_c && dec.grp == GRP_EXT) ? wdata[EXT_W-1:0] : ext_q[c];
    end

    always_comb begin
        ack_any = '0;
        for (int c = 0; c < NCPU; c++) ack_any = ack_any | ack_vec[c];
    end

    assign pending_nx = (pending_q & ~clr_vec & ~ack_any) | pend_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= '0;
            pending_q <= '0;
            bcast_q   <= '0;
            mask_q    <= '0;
            force_q   <= '0;
            ext_q     <= '0;
            idle_q    <= IDLE_RST;
            start_q   <= '0;
        end else begin
            if (lvl_wr) level_q <= wr_lo;
            if (bc_wr)  bcast_q <= wr_lo;
            pending_q <= pending_nx;
            mask_q    <= mask_nx;
            force_q   <= force_nx;
            ext_q     <= ext_nx;
            idle_q    <= idle_q & ~start_nx;
            start_q   <= start_nx;
        end
    end

    always_comb begin
        status_word                   = '0;
        status_word[DW-1 -: CNT_W]    = CNT_W'(NCPU - 1);
        status_word[NCPU-1:0]         = idle_q;
    end

endmodule

// File: rtl/mpic_prio.sv
module mpic_prio
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  vec_t                       level_q,
    input  vec_t                       pending_q,
    input  logic [NCPU-1:0][LINES-1:0] mask_q,
    input  logic [NCPU-1:0][LINES-1:0] force_q,
    output logic [NCPU-1:0][NUM_W-1:0] req_q
);

    logic [NCPU-1:0][NUM_W-1:0] req_nx;

    for (genvar c = 0; c < NCPU; c++) begin : g_arb
        vec_t cand, hi_grp, lo_grp, win;
        assign cand     = (pending_q | force_q[c]) & mask_q[c];
        assign hi_grp   = cand & level_q;
        assign lo_grp   = cand & ~level_q;
        assign win      = (hi_grp != '0) ? hi_grp : lo_grp;
        assign req_nx[c] = top_bit(win);
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_nx;
    end

endmodule

// File: rtl/mpic_rdmux.sv
module mpic_rdmux
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  dec_t                       dec,
    input  vec_t                       level_q,
    input  vec_t                       pending_q,
    input  vec_t                       bcast_q,
    input  logic [NCPU-1:0][LINES-1:0] mask_q,
    input  logic [NCPU-1:0][LINES-1:0] force_q,
    input  logic [NCPU-1:0][EXT_W-1:0] ext_q,
    input  logic [DW-1:0]              status_word,
    output logic [DW-1:0]              rdata
);

    vec_t              sel_mask, sel_force;
    logic [EXT_W-1:0]  sel_ext;

    always_comb begin
        sel_mask  = '0;
        sel_force = '0;
        sel_ext   = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (dec.idx == IDX_W'(c)) begin
                sel_mask  = mask_q[c];
                sel_force = force_q[c];
                sel_ext   = ext_q[c];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            case (dec.grp)
                GRP_GLOBAL: begin
                    case (dec.gsel)
                        G_LEVEL: rdata = DW'(level_q);
                        G_PEND:  rdata = DW'(pending_q);
                        G_ALIAS: rdata = DW'(force_q[0]);
                        G_START: rdata = status_word;
                        G_BCAST: rdata = DW'(bcast_q);
                        default: rdata = '0;
                    endcase
                end
                GRP_MASK:  rdata = DW'(sel_mask);
                GRP_FORCE: rdata = DW'(sel_force);
                default:   rdata = DW'(sel_ext);
            endcase
        end
    end

endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AW-1:0]         reg_addr,
    input  logic                  reg_wr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    input  logic [LINES-1:0]      irq_lines,
    input  logic [NCPU-1:0]       ack_valid,
    input  logic [NUM_W*NCPU-1:0] ack_num,
    output logic [NUM_W*NCPU-1:0] irq_req,
    output logic [NCPU-1:0]       cpu_start
);

    dec_t                       dec;
    vec_t                       level_q, pending_q, bcast_q;
    logic [NCPU-1:0][LINES-1:0] mask_q, force_q;
    logic [NCPU-1:0][EXT_W-1:0] ext_q;
    logic [NCPU-1:0]            idle_q;
    logic [DW-1:0]              status_word;
    logic [NCPU-1:0][NUM_W-1:0] req_q;

    assign dec = decode(reg_addr, NCPU);

    mpic_regfile #(.NCPU(NCPU)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (reg_wr),
        .dec         (dec),
        .wdata       (reg_wdata),
        .lines       (irq_lines),
        .ack_valid   (ack_valid),
        .ack_num     (ack_num),
        .level_q     (level_q),
        .pending_q   (pending_q),
        .bcast_q     (bcast_q),
        .mask_q      (mask_q),
        .force_q     (force_q),
        .ext_q       (ext_q),
        .idle_q      (idle_q),
        .start_q     (cpu_start),
        .status_word (status_word)
    );

    mpic_prio #(.NCPU(NCPU)) u_prio (
        .clk       (clk),
        .rst       (rst),
        .level_q   (level_q),
        .pending_q (pending_q),
        .mask_q    (mask_q),
        .force_q   (force_q),
        .req_q     (req_q)
    );

    mpic_rdmux #(.NCPU(NCPU)) u_rd (
        .dec         (dec),
        .level_q     (level_q),
        .pending_q   (pending_q),
        .bcast_q     (bcast_q),
        .mask_q      (mask_q),
        .force_q     (force_q),
        .ext_q       (ext_q),
        .status_word (status_word),
        .rdata       (reg_rdata)
    );

    assign irq_req = req_q;

endmodule

// File: rtl/mpic_checker.sv
module mpic_checker
    import mpic_pkg::*;
#(
    parameter int NCPU = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic [AW-1:0]         reg_addr,
    input logic                  reg_wr,
    input logic [NCPU-1:0]       wr_lo,
    input logic [LINES-1:0]      irq_lines,
    input logic [NCPU-1:0]       ack_valid,
    input logic [NUM_W*NCPU-1:0] ack_num,
    input logic [NUM_W*NCPU-1:0] irq_req,
    input logic [NCPU-1:0]       cpu_start,
    input logic [LINES-1:0]      pending,
    input logic [LINES-1:0]      bcast,
    input logic [LINES*NCPU-1:0] mask_flat,
    input logic [NCPU-1:0]       idle
);

    logic [LINES*NCPU-1:0] mask_d;
    always_ff @(posedge clk) mask_d <= mask_flat;

    // R10: lane 0 never receives a start pulse
    a_r10_no_start_lane0: assert property (@(posedge clk) disable iff (rst)
        !cpu_start[0]);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu_chk
        // R10: a pulse only follows a start-control write with that bit set
        a_r10_start_cause: assert property (@(posedge clk) disable iff (rst)
            cpu_start[c] |-> $past(reg_wr && reg_addr == 8'h10 && wr_lo[c]));

        // R10: an idle flag, once cleared, never comes back
        a_r10_idle_sticky: assert property (@(posedge clk) disable iff (rst)
            !$rose(idle[c]));

        // R5: a nonzero request names an interrupt the mask enabled
        a_r5_req_masked: assert property (@(posedge clk) disable iff (rst)
            (irq_req[NUM_W*c +: NUM_W] != '0) |->
            mask_d[LINES*c + int'(irq_req[NUM_W*c +: NUM_W])]);

        // R9: an acknowledge without a competing line event clears pending
        a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (ack_valid[c] && !irq_lines[ack_num[NUM_W*c +: NUM_W]]) |=>
            !pending[$past(ack_num[NUM_W*c +: NUM_W])]);
    end

    for (genvar k = 1; k < LINES; k++) begin : g_line_chk
        // R3: a non-broadcast line event always lands in pending
        a_r3_line_sets: assert property (@(posedge clk) disable iff (rst)
            (irq_lines[k] && !bcast[k]) |=> pending[k]);
    end

endmodule

bind mp_irq_ctrl mpic_checker #(.NCPU(NCPU)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .wr_lo     (reg_wdata[NCPU-1:0]),
    .irq_lines (irq_lines),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .irq_req   (irq_req),
    .cpu_start (cpu_start),
    .pending   (pending_q),
    .bcast     (bcast_q),
    .mask_flat (mask_q),
    .idle      (idle_q)
);

// File: tb/mp_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mp_irq_ctrl_tb_top;

    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [15:0]   irq_lines = '0;
    logic [NC-1:0] ack_valid = '0;
    logic [4*NC-1:0] ack_num = '0;
    logic [4*NC-1:0] irq_req;
    logic [NC-1:0] cpu_start;

    always #10 clk = ~clk;

    mp_irq_ctrl #(.NCPU(NC)) dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
        .ack_valid(ack_valid), .ack_num(ack_num), .irq_req(irq_req),
        .cpu_start(cpu_start)
    );

    typedef struct {
        string       tag;
        int          kind;   // 0 read data, 1 request of cpu sel, 2 start vector
        int          sel;
        logic [31:0] exp;
    } item_t;

    item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Monitor: pops expected items and compares them away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = 32'(irq_req[4*it.sel +: 4]);
                default: act = 32'(cpu_start);
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        tick();
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.tag = tag; it.kind = 0; it.sel = 0; it.exp = e;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic exp_req(input int c, input logic [3:0] e, input string tag);
        item_t it;
        tick();
        it.tag = tag; it.kind = 1; it.sel = c; it.exp = 32'(e);
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic exp_start(input bit wait_edge, input logic [NC-1:0] e, input string tag);
        item_t it;
        if (wait_edge) tick();
        it.tag = tag; it.kind = 2; it.sel = 0; it.exp = 32'(e);
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic pulse_line(input int k);
        tick();
        irq_lines[k] = 1'b1;
        tick();
        irq_lines = '0;
    endtask

    task automatic ack(input int c, input logic [3:0] k);
        tick();
        ack_valid[c] = 1'b1;
        ack_num[4*c +: 4] = k;
        tick();
        ack_valid = '0;
        ack_num = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R1 reset state
        exp_rd(8'h10, 32'h3000_000E, "R1 start-control reset");
        exp_rd(8'h00, 32'h0, "R1 level reset");
        exp_rd(8'h04, 32'h0, "R1 pending reset");
        exp_rd(8'h40, 32'h0, "R1 mask reset");
        exp_req(0, 4'd0, "R1 request reset");
        exp_start(1'b0, '0, "R1 start pulses reset");

        // R2 bit 0 dropped
        wr(8'h00, 32'hFFFF_FFFF);
        exp_rd(8'h00, 32'h0000_FFFE, "R2 level bit0 dropped");
        wr(8'h00, 32'h0000_0004);
        exp_rd(8'h00, 32'h0000_0004, "R12 level offset");
        wr(8'h40, 32'h0000_FFFF);
        exp_rd(8'h40, 32'h0000_FFFE, "R2 mask bit0 dropped");
        wr(8'h44, 32'h0000_0010);

        // R3 / R5 pending and priority
        pulse_line(3);
        exp_rd(8'h04, 32'h0000_0008, "R3 line 3 sets pending");
        exp_req(0, 4'd3, "R5 single candidate");
        exp_req(1, 4'd0, "R5 masked out gives 0");
        pulse_line(4);
        exp_rd(8'h04, 32'h0000_0018, "R3 line 4 sets pending");
        exp_req(0, 4'd4, "R5 highest in low group");
        exp_req(1, 4'd4, "R5 cpu1 enabled line");
        pulse_line(2);
        exp_req(0, 4'd2, "R5 high level group wins over higher number");
        exp_req(1, 4'd4, "R5 cpu1 unaffected");

        // R9 acknowledge
        ack(0, 4'd2);
        exp_rd(8'h04, 32'h0000_0018, "R9 ack clears pending bit");
        exp_req(0, 4'd4, "R9 request after ack");

        // R8 pending read-only, clear register
        wr(8'h04, 32'h0000_FFFF);
        exp_rd(8'h04, 32'h0000_0018, "R8 pending ignores write");
        wr(8'h0C, 32'h0000_0011);
        exp_rd(8'h04, 32'h0000_0008, "R8 clear removes bits");
        exp_rd(8'h0C, 32'h0, "R8 clear reads 0");
        exp_req(1, 4'd0, "R8 request drops after clear");

        // R6 per-processor force set/clear
        wr(8'h84, 32'h0000_0021);
        exp_rd(8'h84, 32'h0000_0020, "R6 force set, R2 bit0 dropped");
        wr(8'h44, 32'h0000_0030);
        exp_req(1, 4'd5, "R5 force feeds candidates");
        wr(8'h84, 32'h0020_0040);
        exp_rd(8'h84, 32'h0000_0040, "R6 set and clear in one write");
        exp_req(1, 4'd0, "R6 cleared force no request");
        wr(8'h84, 32'h0040_0040);
        exp_rd(8'h84, 32'h0, "R6 clear wins over set");

        // R7 alias replaces
        wr(8'h80, 32'h0000_0002);
        exp_rd(8'h80, 32'h0000_0002, "R6 cpu0 force set");
        wr(8'h08, 32'h0000_0C01);
        exp_rd(8'h80, 32'h0000_0C00, "R7 alias replaces force0");
        exp_rd(8'h08, 32'h0000_0C00, "R7 alias reads force0");
        exp_req(0, 4'd11, "R5 highest of mixed sources");

        ack(0, 4'd11);
        exp_rd(8'h80, 32'h0000_0400, "R9 ack clears own force bit");
        exp_rd(8'h04, 32'h0000_0008, "R9 pending kept for other number");
        exp_req(0, 4'd10, "R9 request after force ack");
        ack(1, 4'd3);
        exp_rd(8'h04, 32'h0, "R9 ack from cpu1 clears pending");

        // R4 broadcast
        wr(8'h14, 32'h0000_0081);
        exp_rd(8'h14, 32'h0000_0080, "R2 broadcast bit0 dropped");
        pulse_line(7);
        exp_rd(8'h04, 32'h0, "R4 broadcast leaves pending");
        exp_rd(8'h80, 32'h0000_0480, "R4 broadcast into cpu0 force");
        exp_rd(8'h84, 32'h0000_0080, "R4 broadcast into cpu1 force");
        exp_rd(8'h8C, 32'h0000_0080, "R4 R12 broadcast into cpu3 force");
        exp_req(0, 4'd10, "R5 low group highest");

        wr(8'h0C, 32'h0000_0080);
        exp_rd(8'h84, 32'h0, "R8 clear hits every force");
        exp_rd(8'h80, 32'h0000_0400, "R8 other force bits kept");

        // R3 line wins over clear
        tick();
        irq_lines[9] = 1'b1;
        reg_addr = 8'h0C; reg_wr = 1'b1; reg_wdata = 32'h0000_0200;
        tick();
        irq_lines = '0; reg_wr = 1'b0; reg_wdata = '0;
        exp_rd(8'h04, 32'h0000_0200, "R3 set wins over clear");
        wr(8'h0C, 32'h0000_0200);
        exp_rd(8'h04, 32'h0, "R8 later clear succeeds");

        // R10 start control
        wr(8'h10, 32'h0000_0005);
        exp_start(1'b0, 4'b0100, "R10 start pulse lane 2");
        exp_start(1'b1, 4'b0000, "R10 pulse lasts one cycle");
        exp_rd(8'h10, 32'h3000_000A, "R10 idle bit cleared");
        wr(8'h10, 32'h0);
        exp_rd(8'h10, 32'h3000_000A, "R10 zero does not set");

        // R11 extension
        wr(8'hC4, 32'hFFFF_FFFF);
        exp_rd(8'hC4, 32'h0000_000F, "R11 extension keeps 4 bits");

        // R12 unmapped
        exp_rd(8'h18, 32'h0, "R12 gap reads 0");
        wr(8'h50, 32'h0000_FFFF);
        exp_rd(8'h50, 32'h0, "R12 slot beyond NCPU reads 0");
        exp_rd(8'h4C, 32'h0, "R12 write beyond NCPU ignored");
        exp_rd(8'h42, 32'h0, "R12 misaligned reads 0");
        exp_rd(8'h40, 32'h0000_FFFE, "R12 mask0 untouched");

        tick();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule